// File: doc/BRIEF.md
# RSS Hash Queue Selector

This block spreads received IPv4 flows across receive queues. For each packet it takes a 16-bit sideband descriptor and a 96-bit flow tuple (source address, destination address, source port, destination port). When hashing is enabled and the descriptor shows an unfragmented IPv4 TCP or UDP packet, it computes a Toeplitz hash of the tuple with a 128-bit secret key. The low hash bits then index an indirection table. Any other packet, or any packet while hashing is off, reads table entry 0.

Each table entry returns three fields: a destination queue id, a free-pool select and a next-pool select. Software fills the table through a simple register write port. It normally spreads the entries round-robin over its active queues, so entry i points at queue i mod N. The same port also loads the control register and the four key words. Results come out through a two-stage pipeline: hash, then table read. The block accepts a new packet every cycle.

Top module: `rss_queue_sel`

## Requirements
- R1: The register at address 0x00 is the control register. Bit 0 enables hashing and bits [3:1] select the mode; mode code 1 selects the 12-byte IPv4 tuple. A packet is hashed only when bit 0 is 1 and the mode is 1. Otherwise the packet reads table entry 0.
- R2: The 128-bit key is written as four 32-bit words at addresses 0x01 to 0x04. Address 0x01 holds the first key bits, key[127:96], and address 0x04 holds key[31:0].
- R3: The hash is a 32-bit Toeplitz hash. The tuple is laid out as source IP in bits [95:64], destination IP in [63:32], source port in [31:16] and destination port in [15:0]. For each set tuple bit t[95-i], the key window key[127-i -: 32] is XORed into the hash.
- R4: A hashed packet reads the table entry given by hash bits [6:0], in a 128-entry table.
- R5: A write to address 0x80|idx loads table entry idx. Data bits [11:0] hold the queue id, [15:12] the free-pool select and [19:16] the next-pool select. The entry's three fields appear on outQueueId, outFreePoolSel and outNextPoolSel.
- R6: The sideband descriptor is laid out as fragment flag at [13], L4 protocol at [12:11] (0 TCP, 1 UDP, 2 or 3 other), IP version at [10] (0 IPv4, 1 other) and header-length code at [9:0]. A packet is hashed only if the fragment flag is 0, the version is IPv4 and the protocol is TCP or UDP. Otherwise it reads entry 0.
- R7: The header-length code, (MAC length << 5) | IHL (for example 0x1C5 for 14 and 5), does not affect the result.
- R8: outValid rises exactly two rising edges after the edge that samples pktValid. Back-to-back packets give back-to-back results in order.
- R9: After reset, outValid and all output fields are 0, hashing is disabled, the key is zero and every table entry is zero.
- R10: While outValid is low, the output fields hold their last value.
- R11: Writes to addresses 0x05 to 0x7F change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Register write strobe |
| cfgAddr | input | 8 | Register write address |
| cfgWrData | input | 32 | Register write data |
| pktValid | input | 1 | Packet descriptor strobe |
| pktSband | input | 16 | Sideband descriptor |
| pktTuple | input | 96 | IPv4 flow tuple |
| outValid | output | 1 | Result strobe |
| outQueueId | output | 12 | Destination queue id |
| outFreePoolSel | output | 4 | Free-pool select |
| outNextPoolSel | output | 4 | Next-pool select |

## Verification
The bench compares every result against a Toeplitz model written bit-serially with a sliding key window. A design that reversed the key word order, the tuple bit order or the window direction would select the wrong entry on hashed packets. Each gating condition is tested on its own: fragment set, IPv6, protocol "other" and reserved, hashing disabled, and a wrong mode. A design that ignored any one of them would return a hashed entry where entry 0 was expected. A stream of back-to-back packets exposes a pipeline that drops or reorders results. A rewritten last key word and stray writes into the unused address range expose key-decode and address-decode errors.

// File: rtl/rss_pkg.sv
package rss_pkg;

  typedef enum logic [1:0] {
    PROTO_TCP   = 2'd0,
    PROTO_UDP   = 2'd1,
    PROTO_OTHER = 2'd2,
    PROTO_RSVD  = 2'd3
  } l4Proto_t;

  typedef struct packed {
    logic [1:0] spare;
    logic       frag;
    l4Proto_t   proto;
    logic       ipVer;
    logic [4:0] macLen;
    logic [4:0] ihl;
  } sband_t;

  typedef struct packed {
    logic ctrlWe;
    logic keyWe;
    logic tblWe;
    logic s1Load;
    logic s1Hash;
    logic s2Load;
  } ctrlStrobes_t;

  localparam logic [2:0] MODE_IPV4_12B = 3'd1;

endpackage

// File: rtl/rss_ctrl.sv
module rss_ctrl
  import rss_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int MODE_W    = 3,
  parameter int KEY_WORDS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [MODE_W:0]   ctrlData,
  input  logic              pktValid,
  input  logic [15:0]       pktSband,
  output ctrlStrobes_t      strobes,
  output logic              rssEnable,
  output logic              outValid
);

  localparam logic [ADDR_W-1:0] CTRL_ADDR = '0;
  localparam logic [ADDR_W-1:0] KEY_LAST  = ADDR_W'(KEY_WORDS);

  sband_t           sb;
  logic [MODE_W-1:0] rssMode;
  logic             s1Valid;
  logic             protoOk;
  logic [10:0]      sbUnused;

  assign sb       = sband_t'(pktSband);
  assign sbUnused = {sb.spare, sb.macLen, sb.ihl, 1'b0};
  assign protoOk  = (sb.proto == PROTO_TCP) || (sb.proto == PROTO_UDP);

  always_comb begin
    strobes        = '0;
    strobes.ctrlWe = cfgWrEn && (cfgAddr == CTRL_ADDR);
    strobes.keyWe  = cfgWrEn && (cfgAddr != CTRL_ADDR) && (cfgAddr <= KEY_LAST);
    strobes.tblWe  = cfgWrEn && cfgAddr[ADDR_W-1];
    strobes.s1Load = pktValid;
    strobes.s1Hash = rssEnable && (rssMode == MODE_W'(MODE_IPV4_12B)) &&
                     !sb.frag && (sb.ipVer == 1'b0) && protoOk;
    strobes.s2Load = s1Valid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rssEnable <= 1'b0;
      rssMode   <= '0;
    end else if (strobes.ctrlWe) begin
      rssEnable <= ctrlData[0];
      rssMode   <= ctrlData[MODE_W:1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid  <= 1'b0;
      outValid <= 1'b0;
    end else begin
      s1Valid  <= pktValid;
      outValid <= s1Valid;
    end
  end

endmodule

// File: rtl/rss_datapath.sv
module rss_datapath
  import rss_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int TUPLE_W   = 96,
  parameter int HASH_W    = 32,
  parameter int TBL_DEPTH = 128,
  parameter int QID_W     = 12,
  parameter int FP_W      = 4,
  parameter int NFP_W     = 4,
  localparam int KEY_W     = TUPLE_W + HASH_W,
  localparam int KEY_WORDS = KEY_W / DATA_W,
  localparam int IDX_W     = $clog2(TBL_DEPTH),
  localparam int ENT_W     = QID_W + FP_W + NFP_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [ADDR_W-1:0]  cfgAddr,
  input  logic [DATA_W-1:0]  cfgWrData,
  input  logic [TUPLE_W-1:0] pktTuple,
  output logic [IDX_W-1:0]   s1Idx,
  output logic [QID_W-1:0]   outQueueId,
  output logic [FP_W-1:0]    outFreePoolSel,
  output logic [NFP_W-1:0]   outNextPoolSel
);

  logic [DATA_W-1:0] keyReg [KEY_WORDS];
  logic [KEY_W-1:0]  keyFlat;
  logic [HASH_W-1:0] hashVal;
  logic [ENT_W-1:0]  tbl [TBL_DEPTH];
  logic [ENT_W-1:0]  rdEnt;

  // Key word k sits at address k+1; word 0 carries the leading key bits
  for (genvar k = 0; k < KEY_WORDS; k++) begin : g_key
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        keyReg[k] <= '0;
      else if (strobes.keyWe && (cfgAddr == ADDR_W'(k + 1)))
        keyReg[k] <= cfgWrData;
    end
    assign keyFlat[KEY_W-1-k*DATA_W -: DATA_W] = keyReg[k];
  end

  // Toeplitz: each set tuple bit folds in the key window aligned to it
  always_comb begin
    hashVal = '0;
    for (int i = 0; i < TUPLE_W; i++) begin
      if (pktTuple[TUPLE_W-1-i])
        hashVal = hashVal ^ keyFlat[KEY_W-1-i -: HASH_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      s1Idx <= '0;
    else if (strobes.s1Load)
      s1Idx <= strobes.s1Hash ? hashVal[IDX_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < TBL_DEPTH; e++) tbl[e] <= '0;
    end else if (strobes.tblWe) begin
      tbl[cfgAddr[IDX_W-1:0]] <= cfgWrData[ENT_W-1:0];
    end
  end

  assign rdEnt = tbl[s1Idx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outQueueId     <= '0;
      outFreePoolSel <= '0;
      outNextPoolSel <= '0;
    end else if (strobes.s2Load) begin
      outQueueId     <= rdEnt[QID_W-1:0];
      outFreePoolSel <= rdEnt[QID_W +: FP_W];
      outNextPoolSel <= rdEnt[QID_W+FP_W +: NFP_W];
    end
  end

endmodule

// File: rtl/rss_queue_sel.sv
module rss_queue_sel
  import rss_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int TUPLE_W   = 96,
  parameter int HASH_W    = 32,
  parameter int TBL_DEPTH = 128,
  parameter int QID_W     = 12,
  parameter int FP_W      = 4,
  parameter int NFP_W     = 4,
  parameter int MODE_W    = 3,
  localparam int IDX_W     = $clog2(TBL_DEPTH),
  localparam int KEY_WORDS = (TUPLE_W + HASH_W) / DATA_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [ADDR_W-1:0]  cfgAddr,
  input  logic [DATA_W-1:0]  cfgWrData,
  input  logic               pktValid,
  input  logic [15:0]        pktSband,
  input  logic [TUPLE_W-1:0] pktTuple,
  output logic               outValid,
  output logic [QID_W-1:0]   outQueueId,
  output logic [FP_W-1:0]    outFreePoolSel,
  output logic [NFP_W-1:0]   outNextPoolSel
);

  ctrlStrobes_t     strobes;
  logic             rssEnable;
  logic             useHash;
  logic [IDX_W-1:0] s1Idx;

  assign useHash = strobes.s1Hash;

  rss_ctrl #(
    .ADDR_W(ADDR_W), .MODE_W(MODE_W), .KEY_WORDS(KEY_WORDS)
  ) ctrl_i (
    .clk(clk), .rstN(rstN),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .ctrlData(cfgWrData[MODE_W:0]),
    .pktValid(pktValid), .pktSband(pktSband),
    .strobes(strobes), .rssEnable(rssEnable), .outValid(outValid)
  );

  rss_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TUPLE_W(TUPLE_W), .HASH_W(HASH_W),
    .TBL_DEPTH(TBL_DEPTH), .QID_W(QID_W), .FP_W(FP_W), .NFP_W(NFP_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .cfgAddr(cfgAddr), .cfgWrData(cfgWrData), .pktTuple(pktTuple),
    .s1Idx(s1Idx), .outQueueId(outQueueId),
    .outFreePoolSel(outFreePoolSel), .outNextPoolSel(outNextPoolSel)
  );

endmodule

// File: rtl/rss_queue_sel_chk.sv
module rss_queue_sel_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 7,
  parameter int QID_W  = 12,
  parameter int FP_W   = 4,
  parameter int NFP_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWrEn,
  input logic [ADDR_W-1:0] cfgAddr,
  input logic [DATA_W-1:0] cfgWrData,
  input logic              pktValid,
  input logic              outValid,
  input logic [QID_W-1:0]  outQueueId,
  input logic [FP_W-1:0]   outFreePoolSel,
  input logic [NFP_W-1:0]  outNextPoolSel,
  input logic              rssEnable,
  input logic              useHash,
  input logic [IDX_W-1:0]  s1Idx
);

  p_ctrl_enable_r1: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgAddr == '0) |=> (rssEnable == $past(cfgWrData[0])));

  p_bypass_entry0_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && !useHash) |=> (s1Idx == '0));

  p_latency_rise_r8: assert property (@(posedge clk) disable iff (!rstN)
    pktValid |=> ##1 outValid);

  p_latency_only_r8: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(pktValid, 2));

  p_hold_fields_r10: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> ($stable(outQueueId) && $stable(outFreePoolSel) &&
                   $stable(outNextPoolSel)));

endmodule

bind rss_queue_sel rss_queue_sel_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
  .QID_W(QID_W), .FP_W(FP_W), .NFP_W(NFP_W)
) chk_i (.*);

// File: tb/rss_queue_sel_tb.sv
module rss_queue_sel_tb_top;

  localparam int NQ = 5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [7:0]  cfgAddr = '0;
  logic [31:0] cfgWrData = '0;
  logic        pktValid = 1'b0;
  logic [15:0] pktSband = '0;
  logic [95:0] pktTuple = '0;
  logic        outValid;
  logic [11:0] outQueueId;
  logic [3:0]  outFreePoolSel;
  logic [3:0]  outNextPoolSel;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [127:0] mKey = '0;
  logic         mEn = 1'b0;
  logic [2:0]   mMode = '0;
  logic [19:0]  mTbl [128];

  // stimulus vectors: {sideband, tuple}
  localparam logic [111:0] VECS [8] = '{
    {16'h01C5, 96'h420995bb_a18e6450_0aea06e6},  // TCP IPv4
    {16'h09C5, 96'hc75c6f02_41458c53_37961283},  // UDP IPv4
    {16'h01C0, 96'h1813c65f_0c16cfb8_32629488},  // TCP, IHL field 0 (R7)
    {16'h21C5, 96'h420995bb_a18e6450_0aea06e6},  // fragment (R6)
    {16'h05C5, 96'hc75c6f02_41458c53_37961283},  // not IPv4 (R6)
    {16'h11C5, 96'h1813c65f_0c16cfb8_32629488},  // proto other (R6)
    {16'h19C5, 96'hdeadbeef_01020304_ffff0001},  // proto reserved (R6)
    {16'h0BFF, 96'hdeadbeef_01020304_ffff0001}   // UDP, odd header code (R7)
  };

  rss_queue_sel dut_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .pktValid(pktValid), .pktSband(pktSband),
    .pktTuple(pktTuple), .outValid(outValid), .outQueueId(outQueueId),
    .outFreePoolSel(outFreePoolSel), .outNextPoolSel(outNextPoolSel)
  );

  always #2.5 clk = ~clk;

  function automatic logic [31:0] refHash(logic [127:0] k, logic [95:0] t);
    logic [31:0] win = k[127:96];
    logic [31:0] acc = '0;
    for (int b = 0; b < 96; b++) begin
      if (t[95-b]) acc ^= win;
      win = {win[30:0], k[95-b]};
    end
    return acc;
  endfunction

  function automatic logic [19:0] refEntry(logic [15:0] sb, logic [95:0] t);
    logic ok;
    ok = mEn && (mMode == 3'd1) && !sb[13] && !sb[10] && (sb[12:11] < 2'd2);
    return ok ? mTbl[refHash(mKey, t)[6:0]] : mTbl[0];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
    if (a == 8'h00) begin mEn = d[0]; mMode = d[3:1]; end
    else if (a >= 8'h01 && a <= 8'h04) mKey[127-32*(a-1) -: 32] = d;
    else if (a[7]) mTbl[a[6:0]] = d[19:0];
  endtask

  task automatic checkOut(string req, logic [19:0] exp);
    check(req, {31'b0, outValid}, 32'd1);
    check(req, {20'b0, outQueueId}, {20'b0, exp[11:0]});
    check(req, {28'b0, outFreePoolSel}, {28'b0, exp[15:12]});
    check(req, {28'b0, outNextPoolSel}, {28'b0, exp[19:16]});
  endtask

  task automatic sendPkt(string req, logic [111:0] v);
    logic [19:0] exp;
    exp = refEntry(v[111:96], v[95:0]);
    @(negedge clk);
    pktValid = 1'b1; pktSband = v[111:96]; pktTuple = v[95:0];
    @(negedge clk);
    pktValid = 1'b0;
    check({req, " (R8 not early)"}, {31'b0, outValid}, 32'd0);
    @(negedge clk);
    checkOut(req, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [19:0] hold;
    for (int i = 0; i < 128; i++) mTbl[i] = '0;
    repeat (4) @(negedge clk);
    check("R9 outValid reset", {31'b0, outValid}, 32'd0);
    check("R9 queue reset", {20'b0, outQueueId}, 32'd0);
    check("R9 pools reset", {24'b0, outFreePoolSel, outNextPoolSel}, 32'd0);
    rstN = 1'b1;

    // R9/R1: default disabled, table zero
    sendPkt("R9 R1 default entry", VECS[0]);

    // R2 key, R5 round-robin table, R1 enable with mode 1
    cfgWrite(8'h01, 32'h6d5a56da);
    cfgWrite(8'h02, 32'h255b0ec2);
    cfgWrite(8'h03, 32'h4167253d);
    cfgWrite(8'h04, 32'h43a38fb0);
    for (int i = 0; i < 128; i++)
      cfgWrite(8'h80 | 8'(i), {12'b0, 4'(15 - i % NQ), 4'(i % NQ), 12'(12'h100 + i)});
    cfgWrite(8'h00, 32'h3);

    // R3 R4 R5 R6 R7 vector walk
    for (int v = 0; v < 8; v++) sendPkt($sformatf("R3 R4 R5 R6 R7 vec%0d", v), VECS[v]);

    // R8 back-to-back stream
    for (int c = 0; c < 7; c++) begin
      @(negedge clk);
      if (c >= 2) checkOut($sformatf("R8 stream %0d", c - 2),
                           refEntry(VECS[c-2][111:96], VECS[c-2][95:0]));
      if (c < 5) begin
        pktValid = 1'b1; pktSband = VECS[c][111:96]; pktTuple = VECS[c][95:0];
      end else pktValid = 1'b0;
    end
    @(negedge clk);
    check("R8 stream end", {31'b0, outValid}, 32'd0);

    // R10 hold while idle
    sendPkt("R10 setup", VECS[1]);
    hold = {outNextPoolSel, outFreePoolSel, outQueueId};
    repeat (3) @(negedge clk);
    check("R10 hold", {12'b0, outNextPoolSel, outFreePoolSel, outQueueId}, {12'b0, hold});

    // R1 disable, wrong mode
    cfgWrite(8'h00, 32'h2);
    sendPkt("R1 disabled", VECS[0]);
    cfgWrite(8'h00, 32'h5);
    sendPkt("R1 wrong mode", VECS[1]);
    cfgWrite(8'h00, 32'h3);

    // R11 stray writes
    cfgWrite(8'h05, 32'hffffffff);
    cfgWrite(8'h7f, 32'hffffffff);
    cfgWrite(8'h40, 32'h00000000);
    sendPkt("R11 stray writes", VECS[0]);
    sendPkt("R11 stray writes udp", VECS[1]);

    // R2 last key word carries key[31:0]
    cfgWrite(8'h04, 32'h0f0f1234);
    sendPkt("R2 last key word", VECS[0]);
    sendPkt("R2 last key word udp", VECS[7]);

    // R5 rewrite entry 0
    cfgWrite(8'h80, 32'h000a5c3e);
    sendPkt("R5 entry0 rewrite", VECS[3]);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule